// File: doc/BRIEF.md
# QPSK Symbol Differential Decoder and Serializer

This block sits at the back end of a QPSK receiver, after the in-phase and quadrature channels have each been reduced to a sign decision. Once per symbol a strobe presents one I bit and one Q bit. The block maps the pair to a quadrant number in Gray order. It subtracts the quadrant of the previous symbol modulo four and turns the difference back into a Gray-coded two-bit value. The transmitter encodes the data differentially, so this removes the four-fold phase ambiguity left by carrier recovery. The two decoded bits then leave one after the other on a single serial line, at twice the symbol rate.

With the default 80 clock cycles per symbol (an 8 MHz clock at 100 ksymbol/s), each output bit lasts 40 cycles and gives 200 kbit/s. A one-cycle bit strobe marks the start of each output bit. A new symbol strobe always takes priority: if one arrives while the previous dibit is still being shifted out, the new dibit replaces it and output restarts with its first bit.

Top module: `qpsk_dd_serializer`

## Requirements
- R1: While reset is asserted and in the first cycle after its release, `ser_bit` and `bit_stb` are both 0.
- R2: The input pair maps to a quadrant as (i_bit,q_bit) = (0,0)→0, (0,1)→1, (1,1)→2, (1,0)→3.
- R3: The dibit sent for a symbol is the Gray code of (current quadrant − previous quadrant) mod 4, with difference 0→00, 1→01, 2→11, 3→10 written as {first bit, second bit}.
- R4: After reset the previous quadrant is 0, so the first symbol is decoded against quadrant 0.
- R5: The clock edge that samples `sym_stb` high makes `bit_stb` 1 for the next cycle, with `ser_bit` equal to the first (upper) bit of the new dibit.
- R6: The first bit stays on `ser_bit` for SYM_CYCLES/2 cycles. After that the second bit appears for SYM_CYCLES/2 cycles, and `bit_stb` pulses for one cycle at the start of the second bit.
- R7: Each symbol produces exactly two bit strobes. Once the second bit has run its full time, `bit_stb` stays 0 and `ser_bit` holds the second bit until the next symbol strobe.
- R8: A symbol strobe that arrives during serialization discards the rest of the old dibit and restarts output with the new dibit's first bit, timed as in R5 and R6.
- R9: `i_bit` and `q_bit` have no effect while `sym_stb` is low. The stored previous quadrant, and so the next decoded dibit, does not depend on them.
- R10: `ser_bit` changes only in cycles where `bit_stb` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sym_stb | input | 1 | One-cycle marker that a new I/Q decision pair is valid |
| i_bit | input | 1 | Sign decision of the in-phase channel |
| q_bit | input | 1 | Sign decision of the quadrature channel |
| ser_bit | output | 1 | Serial decoded data, first bit of each dibit first |
| bit_stb | output | 1 | One-cycle marker at the start of each serial bit |

## Verification
On every cycle the assertions check the following:
- A symbol strobe is followed by a bit strobe that carries the decoder's upper bit.
- The serial line moves only on a strobe.
- The previous-quadrant register changes only when a symbol is accepted, and then takes that symbol's quadrant.
- The bit counter stays inside its window.
- An idle serializer never strobes.

Some properties only the bench's scenarios can show. These are the arithmetic of the Gray mapping and the modulo-four difference over long random symbol runs, the exact 40-cycle placement of the second strobe, and restarts both in the first half and in the second half of a symbol. The bench also shows that I/Q activity between strobes leaves the next decoded dibit unchanged.

// File: rtl/qdds_pkg.sv
package qdds_pkg;
  typedef logic [1:0] quad_t;
  typedef logic [1:0] dibit_t;

  // Gray-order quadrant number of a sign pair.
  function automatic quad_t quad_of(input logic i_s, input logic q_s);
    return {i_s, i_s ^ q_s};
  endfunction

  // Binary two-bit value to Gray code.
  function automatic dibit_t gray_of(input logic [1:0] d);
    return {d[1], d[1] ^ d[0]};
  endfunction

  // Phase step between two quadrants, modulo four, Gray coded.
  function automatic dibit_t step_of(input quad_t cur, input quad_t prev);
    logic [1:0] diff;
    diff = cur - prev;
    return gray_of(diff);
  endfunction
endpackage

// File: rtl/qdds_quadrant.sv
module qdds_quadrant
  import qdds_pkg::*;
(
  input  logic  i_bit,
  input  logic  q_bit,
  output quad_t quad
);
  always_comb quad = quad_of(i_bit, q_bit);

  always_comb begin
    if (!$isunknown({i_bit, q_bit}))
      AST_QUAD_LSB_XOR: assert (quad[0] == (i_bit ^ q_bit)); // R2
  end
endmodule

// File: rtl/qdds_diff_dec.sv
module qdds_diff_dec
  import qdds_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   sym_stb,
  input  quad_t  cur_quad,
  output dibit_t dibit,
  output quad_t  prev_quad
);
  always_ff @(posedge clk) begin
    if (!rst_n)       prev_quad <= '0;
    else if (sym_stb) prev_quad <= cur_quad;
  end

  always_comb dibit = step_of(cur_quad, prev_quad);

  AST_PREV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !sym_stb |=> $stable(prev_quad)); // R9
  AST_PREV_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    sym_stb |=> prev_quad == $past(cur_quad)); // R3
endmodule

// File: rtl/qdds_serializer.sv
module qdds_serializer
  import qdds_pkg::*;
#(
  parameter int BIT_CYCLES = 40
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   load,
  input  dibit_t din,
  output logic   ser_bit,
  output logic   bit_stb,
  output logic   busy,
  output logic   second
);
  localparam int CNT_W = (BIT_CYCLES > 1) ? $clog2(BIT_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BIT_CYCLES - 1);

  logic [CNT_W-1:0] cnt;
  logic             held_lsb;
  logic             bit_done;

  always_comb bit_done = busy && (cnt == CNT_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      busy     <= 1'b0;
      second   <= 1'b0;
      held_lsb <= 1'b0;
      ser_bit  <= 1'b0;
      bit_stb  <= 1'b0;
    end else if (load) begin
      cnt      <= '0;
      busy     <= 1'b1;
      second   <= 1'b0;
      held_lsb <= din[0];
      ser_bit  <= din[1];
      bit_stb  <= 1'b1;
    end else if (bit_done) begin
      cnt     <= '0;
      bit_stb <= !second;
      if (!second) begin
        second  <= 1'b1;
        ser_bit <= held_lsb;
      end else begin
        busy <= 1'b0;
      end
    end else begin
      bit_stb <= 1'b0;
      if (busy) cnt <= cnt + 1'b1;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_LAST); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !load) |=> !bit_stb); // R7
  AST_BIT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_stb |-> $stable(ser_bit)); // R10
  AST_SECOND_STB: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !second && !load && bit_done) |=> (bit_stb && second)); // R6
endmodule

// File: rtl/qpsk_dd_serializer.sv
module qpsk_dd_serializer
  import qdds_pkg::*;
#(
  parameter int SYM_CYCLES = 80
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sym_stb,
  input  logic i_bit,
  input  logic q_bit,
  output logic ser_bit,
  output logic bit_stb
);
  localparam int BIT_CYCLES = SYM_CYCLES / 2;

  quad_t  cur_quad;
  quad_t  prev_quad;
  dibit_t dibit;
  logic   ser_busy;
  logic   ser_second;

  qdds_quadrant u_quad (
    .i_bit (i_bit),
    .q_bit (q_bit),
    .quad  (cur_quad)
  );

  qdds_diff_dec u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .sym_stb   (sym_stb),
    .cur_quad  (cur_quad),
    .dibit     (dibit),
    .prev_quad (prev_quad)
  );

  qdds_serializer #(.BIT_CYCLES(BIT_CYCLES)) u_ser (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (sym_stb),
    .din     (dibit),
    .ser_bit (ser_bit),
    .bit_stb (bit_stb),
    .busy    (ser_busy),
    .second  (ser_second)
  );

  AST_LOAD_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    sym_stb |=> (bit_stb && ser_bit == $past(dibit[1]) && !ser_second)); // R5
  AST_LOAD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    sym_stb |=> ser_busy); // R8
  AST_RESET_OUT: assert property (@(posedge clk)
    !rst_n |=> (!bit_stb && !ser_bit && prev_quad == 2'd0)); // R1
endmodule

// File: tb/sim_qpsk_dd_serializer.sv
module sim_qpsk_dd_serializer;
  localparam int SYM = 80;
  localparam int HALF = SYM / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sym_stb = 1'b0;
  logic i_bit = 1'b0;
  logic q_bit = 1'b0;
  logic ser_bit;
  logic bit_stb;

  int checks = 0;
  int errors = 0;
  int prev_m = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  qpsk_dd_serializer #(.SYM_CYCLES(SYM)) u0 (
    .clk(clk), .rst_n(rst_n), .sym_stb(sym_stb),
    .i_bit(i_bit), .q_bit(q_bit), .ser_bit(ser_bit), .bit_stb(bit_stb)
  );

  function automatic int m_quad(input logic i, input logic q);
    case ({i, q})
      2'b00: return 0;
      2'b01: return 1;
      2'b11: return 2;
      default: return 3;
    endcase
  endfunction

  function automatic logic [1:0] m_gray(input int d);
    case (d)
      0: return 2'b00;
      1: return 2'b01;
      2: return 2'b11;
      default: return 2'b10;
    endcase
  endfunction

  task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // Sends one symbol and follows it for run cycles (run < 2*HALF interrupts).
  task automatic send(input logic i, input logic q, input int run, input string req);
    int c;
    logic [1:0] d;
    int bad;
    c = m_quad(i, q);
    d = m_gray((c - prev_m + 4) % 4);
    prev_m = c;
    @(negedge clk);
    sym_stb = 1'b1; i_bit = i; q_bit = q;
    @(negedge clk);
    sym_stb = 1'b0;
    chk({req, " R5 first strobe/bit"}, {bit_stb, ser_bit}, {1'b1, d[1]});
    bad = 0;
    for (int k = 1; k < run; k++) begin
      i_bit = 1'($urandom); q_bit = 1'($urandom); // R9: ignored
      @(negedge clk);
      if (k == HALF) begin
        chk({req, " R6 second strobe/bit"}, {bit_stb, ser_bit}, {1'b1, d[0]});
      end else if (k < HALF) begin
        if ({bit_stb, ser_bit} !== {1'b0, d[1]}) bad++;
      end else begin
        if ({bit_stb, ser_bit} !== {1'b0, d[0]}) bad++; // R7 and R10
      end
    end
    chk({req, " R10 hold between strobes"}, 2'(bad > 0), 2'b00);
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk("R1 in reset", {bit_stb, ser_bit}, 2'b00);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", {bit_stb, ser_bit}, 2'b00);

    // R4: the first symbol is decoded against quadrant 0; (1,0) is quadrant 3 -> 10.
    send(1'b1, 1'b0, SYM + 3, "R4");
    // R2/R3: walk the quadrants directly.
    send(1'b1, 1'b1, SYM, "R2 q2");
    send(1'b0, 1'b1, SYM, "R2 q1");
    send(1'b0, 1'b0, SYM, "R3 q0");
    send(1'b0, 1'b0, SYM, "R3 zero step");
    // R7: a long idle with I/Q toggling (R9), then a symbol.
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      i_bit = 1'($urandom); q_bit = 1'($urandom);
      chk("R7 idle no strobe", {1'b0, bit_stb}, 2'b00);
    end
    send(1'b1, 1'b1, SYM, "R9 after idle");
    // R8: restart during the first bit and during the second bit.
    send(1'b0, 1'b1, 20, "R8 cut early");
    send(1'b1, 1'b0, 55, "R8 cut late");
    send(1'b1, 1'b1, SYM, "R8 after restart");
    // Random runs.
    for (int n = 0; n < 60; n++) begin
      int run;
      run = (($urandom % 4) == 0) ? (2 + ($urandom % (SYM - 2))) : SYM + int'($urandom % 5);
      send(1'($urandom), 1'($urandom), run, "R3 random");
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule